// File: doc/BRIEF.md
# Integer Arithmetic Unit with Condition Flags

This block performs one integer arithmetic operation per start strobe on two operands. The operations are add, add with carry-in, subtract, subtract with borrow-in, compare, increment, decrement and negate. It returns the result, a destination write-enable and a new set of four condition flags: zero, sign, carry and overflow. The caller supplies the current flag word, so carry-chained multi-word arithmetic works by feeding the returned flags back in.

The result, the flags and a one-cycle done pulse are registered, and appear one clock after the start strobe. Two branch conditions are derived continuously from the registered flags: signed greater-than and unsigned above. A sequencer can use them to decide a jump without decoding the flags itself.

Top module: `int_alu_flags`

## Requirements
- R1: After synchronous reset, result_o is 0, flags_o is 0 (bit 0 zero, bit 1 sign, bit 2 carry, bit 3 overflow), and wr_en_o and done_o are low.
- R2: Opcode 0 (add) yields a+b and opcode 1 (add with carry) yields a+b+flags_i[2], both modulo 2^W. Carry is set on an unsigned carry out of the top bit.
- R3: Opcode 2 (subtract) yields a-b and opcode 3 (subtract with borrow) yields a-b-flags_i[2]. Carry is set when the unsigned subtraction borrows.
- R4: Overflow is set exactly when the signed result of the operation lies outside the W-bit two's complement range.
- R5: For every operation, zero is set iff the result is 0, and sign equals the top bit of the result.
- R6: Opcode 4 (compare) sets the flags exactly as subtract does, holds wr_en_o low and leaves result_o at its previous value.
- R7: Opcodes 5 (increment, a+1) and 6 (decrement, a-1) copy flags_i[2] to the carry flag and update the other three flags.
- R8: Opcode 7 (negate) yields the two's complement of a. Carry is set iff a is nonzero.
- R9: done_o is high for exactly the one cycle after a cycle with start_i high. wr_en_o is high only with done_o, for every opcode except compare. With no start, result_o and flags_o hold.
- R10: sgt_o is high iff zero is clear and sign equals overflow in flags_o. ugt_o is high iff both carry and zero are clear in flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch one operation this cycle |
| op_i | input | 3 | Operation code |
| a_i | input | W | First operand (sole operand for increment, decrement, negate) |
| b_i | input | W | Second operand |
| flags_i | input | 4 | Current flags {overflow, carry, sign, zero} |
| result_o | output | W | Registered result |
| wr_en_o | output | 1 | Destination write-enable, valid with done_o |
| flags_o | output | 4 | Registered new flags {overflow, carry, sign, zero} |
| done_o | output | 1 | One-cycle completion pulse |
| sgt_o | output | 1 | Signed greater-than condition from flags_o |
| ugt_o | output | 1 | Unsigned above condition from flags_o |

## Verification
The block keeps no state beyond the registered outputs. A wrong operand selection or carry-in choice therefore shows up in result_o or flags_o on the very done pulse of the affected operation, and the same pulse exposes the branch outputs derived from those flags. The scoreboard compares every field on every done pulse against a wide-integer model. It targets the edge values 0, all-ones, the most negative and the most positive numbers, where carry, borrow and overflow change. A compare that wrongly writes back, or an increment that disturbs carry, is visible on the write-enable, the held result or flag bit 2 in the cycle right after its start.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_CMP = 3'd4,
    OP_INC = 3'd5,
    OP_DEC = 3'd6,
    OP_NEG = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic ov;
    logic cy;
    logic sg;
    logic zr;
  } alu_flags_t;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int W = 32
) (
  input  alu_pkg::alu_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cy_in,
  output logic [W-1:0]     x,
  output logic [W-1:0]     y,
  output logic             cin,
  output logic             is_sub,
  output logic             keep_cy,
  output logic             writes
);
  import alu_pkg::*;

  always_comb begin
    x       = a;
    y       = b;
    cin     = 1'b0;
    is_sub  = 1'b0;
    keep_cy = 1'b0;
    writes  = 1'b1;
    unique case (op)
      OP_ADD: ;
      OP_ADC: cin = cy_in;
      OP_SUB: begin y = ~b; cin = 1'b1;   is_sub = 1'b1; end
      OP_SBB: begin y = ~b; cin = ~cy_in; is_sub = 1'b1; end
      OP_CMP: begin y = ~b; cin = 1'b1;   is_sub = 1'b1; writes = 1'b0; end
      OP_INC: begin y = '0; cin = 1'b1;   keep_cy = 1'b1; end
      OP_DEC: begin y = '1; cin = 1'b0;   keep_cy = 1'b1; end
      OP_NEG: begin x = '0; y = ~a; cin = 1'b1; is_sub = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_add_core.sv
module alu_add_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu_branch_eval.sv
module alu_branch_eval (
  input  alu_pkg::alu_flags_t fl,
  output logic                sgt,
  output logic                ugt
);
  always_comb begin
    sgt = !fl.zr && (fl.sg == fl.ov);
    ugt = !fl.cy && !fl.zr;
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o,
  output logic         done_o,
  output logic         sgt_o,
  output logic         ugt_o
);
  import alu_pkg::*;

  localparam int MSB = W - 1;

  alu_op_e    op;
  alu_flags_t fin, fnext, fq;
  logic [W-1:0] x, y, sum;
  logic cin, is_sub, keep_cy, writes, cout, ovf;
  logic [W-1:0] res_q;
  logic wr_q, done_q;

  assign op  = alu_op_e'(op_i);
  assign fin = alu_flags_t'(flags_i);

  alu_operand_prep #(.W(W)) prep_i (
    .op(op), .a(a_i), .b(b_i), .cy_in(fin.cy),
    .x(x), .y(y), .cin(cin), .is_sub(is_sub),
    .keep_cy(keep_cy), .writes(writes)
  );

  alu_add_core #(.W(W)) add_i (
    .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
  );

  always_comb begin
    fnext.zr = (sum == '0);
    fnext.sg = sum[MSB];
    fnext.ov = ovf;
    fnext.cy = keep_cy ? fin.cy : (is_sub ? ~cout : cout);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      fq     <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      wr_q   <= start_i && writes;
      if (start_i) begin
        fq <= fnext;
        if (writes) res_q <= sum;
      end
    end
  end

  alu_branch_eval br_i (.fl(fq), .sgt(sgt_o), .ugt(ugt_o));

  assign result_o = res_q;
  assign wr_en_o  = wr_q;
  assign flags_o  = fq;
  assign done_o   = done_q;

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst) start_i |=> done_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !start_i |=> !done_o && $stable(result_o) && $stable(flags_o)); // R9
  AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (rst) wr_en_o |-> done_o); // R9
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst) start_i && op_i == 3'd4 |=> !wr_en_o && $stable(result_o)); // R6
  AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (rst) start_i && (op_i == 3'd5 || op_i == 3'd6) |=> flags_o[2] == $past(flags_i[2])); // R7
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst) done_o && wr_en_o |-> flags_o[0] == (result_o == '0)); // R5
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst) done_o && wr_en_o |-> flags_o[1] == result_o[MSB]); // R5
  AST_SGT_NOT_ZERO: assert property (@(posedge clk) disable iff (rst) sgt_o |-> !flags_o[0]); // R10
  AST_UGT_NO_CARRY: assert property (@(posedge clk) disable iff (rst) ugt_o |-> !flags_o[2]); // R10
endmodule

// File: tb/int_alu_flags_tb_top.sv
module int_alu_flags_tb_top;
  localparam int W = 32;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [3:0] flags_i = '0;
  logic [W-1:0] result_o;
  logic wr_en_o, done_o, sgt_o, ugt_o;
  logic [3:0] flags_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [W-1:0] res;
    logic [3:0]   fl;
    logic         we;
    logic         sgt;
    logic         ugt;
    string        tag;
  } exp_t;

  exp_t sb[$];
  logic [W-1:0] last_res = '0;

  always #10ns clk = ~clk;

  int_alu_flags #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flags_i(flags_i), .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o),
    .done_o(done_o), .sgt_o(sgt_o), .ugt_o(ugt_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic [3:0] fi);
    exp_t e;
    longint sa, sb2, sr, ua, ub, ur;
    logic ci, c;
    logic [W-1:0] r;
    sa = longint'($signed(a)); sb2 = longint'($signed(b));
    ua = longint'({1'b0, a});  ub = longint'({1'b0, b});
    ci = fi[2];
    c = 1'b0; sr = 0; ur = 0;
    case (op)
      3'd0: begin sr = sa + sb2; ur = ua + ub; c = ur >= (64'sd1 <<< W); e.tag = "R2"; end
      3'd1: begin sr = sa + sb2 + ci; ur = ua + ub + ci; c = ur >= (64'sd1 <<< W); e.tag = "R2"; end
      3'd2, 3'd4: begin sr = sa - sb2; ur = ua - ub; c = ur < 0; e.tag = (op == 3'd4) ? "R6" : "R3"; end
      3'd3: begin sr = sa - sb2 - ci; ur = ua - ub - ci; c = ur < 0; e.tag = "R3"; end
      3'd5: begin sr = sa + 1; ur = ua + 1; c = ci; e.tag = "R7"; end
      3'd6: begin sr = sa - 1; ur = ua - 1; c = ci; e.tag = "R7"; end
      default: begin sr = -sa; ur = -ua; c = (a != 0); e.tag = "R8"; end
    endcase
    r = ur[W-1:0];
    e.fl[3] = (sr > longint'(MAXP)) || (sr < -longint'({1'b0, MINN}));
    e.fl[2] = c;
    e.fl[1] = r[W-1];
    e.fl[0] = (r == 0);
    e.we  = (op != 3'd4);
    e.res = e.we ? r : last_res;
    e.sgt = !e.fl[0] && (e.fl[1] == e.fl[3]);
    e.ugt = !e.fl[2] && !e.fl[0];
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [3:0] fi);
    exp_t e;
    @(negedge clk);
    e = model(op, a, b, fi);
    last_res = e.res;
    sb.push_back(e);
    op_i = op; a_i = a; b_i = b; flags_i = fi; start_i = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) begin
        chk("R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "result", result_o, e.res);
        chk("R4", "overflow", flags_o[3], e.fl[3]);
        chk(e.tag, "carry", flags_o[2], e.fl[2]);
        chk("R5", "sign/zero", flags_o[1:0], e.fl[1:0]);
        chk("R9", "write enable", wr_en_o, e.we);
        chk("R10", "branch conds", {sgt_o, ugt_o}, {e.sgt, e.ugt});
      end
    end
  end

  initial begin
    #(20ns * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset result", result_o, 0);
    chk("R1", "reset flags", flags_o, 0);
    chk("R1", "reset we/done", {wr_en_o, done_o}, 0);

    drive(3'd0, 32'd5, 32'd7, 4'h0);          // R2 plain add
    drive(3'd0, ONES, 32'd1, 4'h0);           // R2 carry out, zero
    drive(3'd0, MAXP, 32'd1, 4'h0);           // R4 signed overflow
    drive(3'd1, 32'd10, 32'd20, 4'h4);        // R2 carry-in
    drive(3'd1, ONES, 32'd0, 4'h4);           // R2 carry-in wraps
    drive(3'd2, 32'd3, 32'd5, 4'h0);          // R3 borrow
    drive(3'd2, MINN, 32'd1, 4'h0);           // R4 overflow on sub
    drive(3'd3, 32'd0, 32'd0, 4'h4);          // R3 borrow-in
    drive(3'd3, 32'd9, 32'd4, 4'h0);          // R3 no borrow
    drive(3'd0, 32'h1234, 32'h1, 4'h0);       // sets a known result
    drive(3'd4, 32'd7, 32'd7, 4'h0);          // R6 equal compare
    drive(3'd4, 32'd2, 32'd9, 4'h0);          // R6 below
    drive(3'd4, 32'd9, ONES, 4'h0);           // R10 signed gt, unsigned not above
    drive(3'd5, MAXP, 32'd0, 4'h4);           // R7 inc overflow keeps carry
    drive(3'd5, ONES, 32'd0, 4'h0);           // R7 inc wrap, carry stays 0
    drive(3'd6, MINN, 32'd0, 4'h0);           // R7 dec overflow
    drive(3'd6, 32'd0, 32'd0, 4'h4);          // R7 dec wrap keeps carry
    drive(3'd7, 32'd5, 32'd0, 4'h0);          // R8 negate
    drive(3'd7, 32'd0, 32'd0, 4'h4);          // R8 negate zero
    drive(3'd7, MINN, 32'd0, 4'h0);           // R8/R4 negate most negative
    idle(3);
    held = result_o;
    chk("R9", "idle done/we", {done_o, wr_en_o}, 0);
    idle(2);
    chk("R9", "idle result hold", result_o, held);
    drive(3'd4, 32'd1, 32'd2, 4'h0);          // R6 compare after idle
    idle(1);
    chk("R6", "compare keeps result", result_o, held);
    idle(2);
    chk("R9", "scoreboard drained", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule